// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external 8K x 8 static RAM that has no clock of its own. The host hands over one word access at a time through a valid/ready handshake: an address, a write flag and, for writes, a data byte. The controller turns each request into a sequence of register-driven strobes on the RAM side. These are an active-low and an active-high chip select, an active-low output enable and an active-low write enable. Each phase lasts a parameterised number of clock cycles, so the access, pulse-width, cycle and bus-release minimums of the memory are met at any clock rate the integrator picks.

The shared data bus is split into an output, an output-enable and an input. The controller drives the bus only while the write pulse is active. After any read it keeps the bus released for a programmable turnaround time, which lets the RAM's output buffers switch off first. A standby input deselects the memory to save power. The first access after a deselected period waits through a programmable wake delay. The controller also starts out deselected after reset.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, and until the first request, the RAM is deselected with `ram_ce1_n_o`=1 and `ram_ce2_o`=0, `ram_oe_n_o`=1, `ram_we_n_o`=1, `ram_dq_oe_o`=0 and `rsp_valid_o`=0. `req_ready_o` is 1 while `standby_i` is 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 in the cycle after that edge, and it stays 0 until the access, including its recovery phase, is finished.
- R3: A read keeps the chip selected, holds `ram_we_n_o`=1 and holds `ram_oe_n_o`=0 for exactly `RD_CYC` cycles, with a stable address. The byte present on `ram_dq_i` in the last of those cycles is returned on `rsp_rdata_o`. `rsp_valid_o` is 1 for exactly one cycle, the cycle after `ram_oe_n_o` returns to 1.
- R4: A write holds `ram_we_n_o`=0 for exactly `WR_PULSE_CYC` cycles. Throughout the pulse the chip is selected and `ram_oe_n_o` stays at 1.
- R5: The address is stable for at least one cycle before `ram_we_n_o` falls. From the fall of `ram_we_n_o`, at least `WR_CYC` cycles pass before the next read or write strobe starts.
- R6: `ram_dq_oe_o` is 1 only while `ram_we_n_o` is 0, and it is 1 for the whole pulse. Address and `ram_dq_o` do not change during the pulse.
- R7: The data bus is not driven until at least `TURN_CYC` cycles after `ram_oe_n_o` last rose.
- R8: While `standby_i` is 1, `req_ready_o` is 0 and no request is taken. Once the current access is finished, the RAM is deselected (`ram_ce1_n_o`=1, `ram_ce2_o`=0).
- R9: Every read or write strobe starts at least `WAKE_CYC` cycles after the chip was last selected.
- R10: `rsp_valid_o` is raised only to complete an accepted read, once per read, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (13) | Word address |
| req_wdata_i | input | DATA_W (8) | Write byte |
| standby_i | input | 1 | Deselect the RAM and hold off requests |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | DATA_W (8) | Read byte |
| ram_addr_o | output | ADDR_W (13) | RAM address |
| ram_ce1_n_o | output | 1 | Active-low chip select |
| ram_ce2_o | output | 1 | Active-high chip select |
| ram_oe_n_o | output | 1 | Active-low output enable |
| ram_we_n_o | output | 1 | Active-low write enable |
| ram_dq_o | output | DATA_W (8) | Data driven toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | DATA_W (8) | Data returned from the RAM |

## Verification
The hardest situation to reach is a write accepted right after a read, while the turnaround guard is still counting. It only occurs when the host has the next request waiting at the exact cycle ready returns. The stimulus issues requests back to back with no idle gap, mixes random reads and writes over a small address pool, and adds a directed read-then-write pair. The wake path needs the same care: a request must be held during standby and the next one must land on a freshly selected chip. Directed standby excursions with a request held pending, plus random excursions inside the random phase, cover it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WPULSE,
    ST_WTAIL
  } ctrl_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  // strobe levels held during each state
  function automatic strobe_t strobe_of(ctrl_state_e s);
    strobe_t o;
    o = '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_SLEEP: begin
        o.ce1_n = 1'b1;
        o.ce2   = 1'b0;
      end
      ST_READ: o.oe_n = 1'b0;
      ST_WPULSE: begin
        o.we_n  = 1'b0;
        o.dq_oe = 1'b1;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_guard.sv
module sram_bus_guard #(
  parameter int unsigned TURN_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic clear_o
);

  generate
    if (TURN_CYC == 0) begin : g_none
      logic unused_guard;
      assign unused_guard = clk_i ^ rst_ni ^ arm_i;
      assign clear_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned GW = $clog2(TURN_CYC + 1);
      logic [GW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (arm_i) begin
          cnt_q <= GW'(TURN_CYC);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - GW'(1);
        end
      end

      assign clear_o = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RD_CYC       = 4,
  parameter int unsigned WR_PULSE_CYC = 3,
  parameter int unsigned WR_CYC       = 4,
  parameter int unsigned TURN_CYC     = 2,
  parameter int unsigned WAKE_CYC     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              standby_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce1_n_o,
  output logic              ram_ce2_o,
  output logic              ram_oe_n_o,
  output logic              ram_we_n_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned RD_LEN   = (RD_CYC > 0) ? RD_CYC : 1;
  localparam int unsigned PL_LEN   = (WR_PULSE_CYC > 0) ? WR_PULSE_CYC : 1;
  localparam int unsigned TAIL_LEN = (WR_CYC > PL_LEN) ? WR_CYC - PL_LEN : 1;
  localparam int unsigned WK_LEN   = (WAKE_CYC > 0) ? WAKE_CYC : 1;
  localparam int unsigned MAX_A    = (RD_LEN > PL_LEN) ? RD_LEN : PL_LEN;
  localparam int unsigned MAX_B    = (TAIL_LEN > WK_LEN) ? TAIL_LEN : WK_LEN;
  localparam int unsigned MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_state_e state_q, state_d;
  strobe_t     strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              op_we_q, rsp_q;
  logic              accept, rd_done, tmr_ld, tmr_done, bus_clear;
  logic [CNT_W-1:0]  tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_bus_guard #(.TURN_CYC(TURN_CYC)) i_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (rd_done),
    .clear_o (bus_clear)
  );

  assign req_ready_o = ((state_q == ST_IDLE) || (state_q == ST_SLEEP)) && !standby_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    rd_done = 1'b0;
    case (state_q)
      ST_SLEEP: begin
        if (accept) begin
          state_d = ST_WAKE;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(WK_LEN - 1);
        end
      end
      ST_WAKE: begin
        if (tmr_done) begin
          if (op_we_q) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_READ;
            tmr_ld  = 1'b1;
            tmr_val = CNT_W'(RD_LEN - 1);
          end
        end
      end
      ST_IDLE: begin
        if (standby_i) begin
          state_d = ST_SLEEP;
        end else if (accept) begin
          if (req_we_i) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_READ;
            tmr_ld  = 1'b1;
            tmr_val = CNT_W'(RD_LEN - 1);
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          rd_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSET: begin
        // address already settled; hold until the bus is free
        if (bus_clear) begin
          state_d = ST_WPULSE;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(PL_LEN - 1);
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          state_d = ST_WTAIL;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(TAIL_LEN - 1);
        end
      end
      ST_WTAIL: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      strb_q  <= strobe_of(ST_SLEEP);
    end else begin
      state_q <= state_d;
      strb_q  <= strobe_of(state_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      op_we_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      op_we_q <= req_we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= rd_done;
      if (rd_done) rdata_q <= ram_dq_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign ram_addr_o  = addr_q;
  assign ram_dq_o    = wdata_q;
  assign ram_ce1_n_o = strb_q.ce1_n;
  assign ram_ce2_o   = strb_q.ce2;
  assign ram_oe_n_o  = strb_q.oe_n;
  assign ram_we_n_o  = strb_q.we_n;
  assign ram_dq_oe_o = strb_q.dq_oe;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned WAKE_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              standby_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_ce1_n_o,
  input logic              ram_ce2_o,
  input logic              ram_oe_n_o,
  input logic              ram_we_n_o,
  input logic [DATA_W-1:0] ram_dq_o,
  input logic              ram_dq_oe_o
);

  int unsigned oe_hi_cnt, sel_cnt;
  logic        sel;

  assign sel = !ram_ce1_n_o && ram_ce2_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_hi_cnt <= TURN_CYC;
      sel_cnt   <= 0;
    end else begin
      if (!ram_oe_n_o) oe_hi_cnt <= 0;
      else if (oe_hi_cnt < TURN_CYC + 1) oe_hi_cnt <= oe_hi_cnt + 1;
      if (!sel) sel_cnt <= 0;
      else if (sel_cnt < WAKE_CYC) sel_cnt <= sel_cnt + 1;
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_read_we_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_n_o |-> (ram_we_n_o && sel));

  assert_rsp_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_write_select_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> (sel && ram_oe_n_o));

  assert_addr_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_n_o) |-> $stable(ram_addr_o));

  assert_drive_in_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> !ram_we_n_o);

  assert_pulse_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we_n_o && !$past(ram_we_n_o)) |-> ($stable(ram_addr_o) && $stable(ram_dq_o) && ram_dq_oe_o));

  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_dq_oe_o) |-> (oe_hi_cnt >= TURN_CYC));

  assert_standby_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> !req_ready_o);

  assert_wake_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_oe_n_o || !ram_we_n_o) |-> (sel_cnt >= WAKE_CYC));

  assert_rsp_after_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(ram_oe_n_o));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TURN_CYC (TURN_CYC),
  .WAKE_CYC (WAKE_CYC)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .standby_i   (standby_i),
  .rsp_valid_o (rsp_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_ce1_n_o (ram_ce1_n_o),
  .ram_ce2_o   (ram_ce2_o),
  .ram_oe_n_o  (ram_oe_n_o),
  .ram_we_n_o  (ram_we_n_o),
  .ram_dq_o    (ram_dq_o),
  .ram_dq_oe_o (ram_dq_oe_o)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;

  localparam int RD_CYC   = 4;
  localparam int WR_PULSE = 3;
  localparam int WR_CYC   = 4;
  localparam int TURN     = 2;
  localparam int WAKE     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, standby = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] ram_addr;
  logic ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [7:0] dq_o;
  logic [7:0] dq_i = 8'hzz;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ram_m [int];
  logic [7:0] exp_m [int];
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  sram_cycle_ctrl #(
    .RD_CYC(RD_CYC), .WR_PULSE_CYC(WR_PULSE), .WR_CYC(WR_CYC),
    .TURN_CYC(TURN), .WAKE_CYC(WAKE)
  ) i_sram_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .standby_i(standby),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ram_addr_o(ram_addr), .ram_ce1_n_o(ce1_n), .ram_ce2_o(ce2),
    .ram_oe_n_o(oe_n), .ram_we_n_o(we_n), .ram_dq_o(dq_o),
    .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'(a ^ (a >> 5) ^ 8'h3C);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    return exp_m.exists(a) ? exp_m[a] : init_byte(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // RAM model: write on overlap, read data valid from the next falling edge
  always @(posedge clk) begin
    if (rst_n && !ce1_n && ce2 && !we_n)
      ram_m[int'(ram_addr)] = dq_oe ? dq_o : 8'hxx;
  end

  always @(negedge clk) begin
    if (!ce1_n && ce2 && !oe_n && we_n)
      dq_i <= ram_m.exists(int'(ram_addr)) ? ram_m[int'(ram_addr)] : init_byte(int'(ram_addr));
    else
      dq_i <= 8'hzz;
  end

  // port monitor, sampled at falling edges
  int oe_run = 0, we_run = 0, since_oe_hi = 1000, sel_run = 0, since_we_fall = 1000;
  logic p_oe_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
  logic [12:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sel = !ce1_n && ce2;
      automatic bit start = (!oe_n && p_oe_n) || (!we_n && p_we_n);
      if (since_we_fall < 1000) since_we_fall++;
      if (since_oe_hi < 1000) since_oe_hi++;
      if (start) begin
        check(sel_run >= WAKE, "R9 wake delay before strobe", sel_run, WAKE);
        check(since_we_fall >= WR_CYC, "R5 write cycle length", since_we_fall, WR_CYC);
      end
      if (!oe_n) begin
        oe_run++;
        check(we_n && sel, "R3 read strobes", we_n, 1);
        if (!p_oe_n) check(ram_addr == p_addr, "R3 read address stable", ram_addr, p_addr);
      end else if (!p_oe_n) begin
        check(oe_run == RD_CYC, "R3 output enable length", oe_run, RD_CYC);
        oe_run = 0;
        since_oe_hi = 0;
      end
      if (!we_n) begin
        we_run++;
        check(oe_n && sel, "R4 write strobes", oe_n, 1);
        check(dq_oe == 1'b1, "R6 bus driven in pulse", dq_oe, 1);
        check(ram_addr == p_addr, "R5 address setup and hold", ram_addr, p_addr);
        if (p_we_n) since_we_fall = 0;
      end else if (!p_we_n) begin
        check(we_run == WR_PULSE, "R4 write pulse length", we_run, WR_PULSE);
        we_run = 0;
      end
      if (dq_oe && we_n) check(0, "R6 bus driven outside pulse", dq_oe, 0);
      if (dq_oe && !p_dq_oe)
        check(since_oe_hi >= TURN, "R7 bus turnaround", since_oe_hi, TURN);
      if (rsp_valid || (oe_n && !p_oe_n))
        check(rsp_valid == (oe_n && !p_oe_n), "R10 response timing", rsp_valid, 1);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected response", 1, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(rsp_rdata === e, "R3 read data", rsp_rdata, e);
        end
      end
      if (sel) sel_run++; else sel_run = 0;
      p_oe_n = oe_n; p_we_n = we_n; p_dq_oe = dq_oe; p_addr = ram_addr;
    end
  end

  task automatic issue(input bit wr, input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = wr; req_addr = 13'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) exp_m[a] = d;
    else exp_q.push_back(exp_rd(a));
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 ready low after accept", req_ready, 0);
  endtask

  task automatic standby_trip(input int hold);
    @(negedge clk);
    standby = 1'b1;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 13'd5;
    repeat (10 + hold) @(negedge clk);
    check(ce1_n == 1'b1 && ce2 == 1'b0, "R8 deselect in standby", {ce1_n, ce2}, 2);
    check(!req_ready, "R8 ready low in standby", req_ready, 0);
    check(oe_n && we_n, "R8 no strobes in standby", {oe_n, we_n}, 3);
    req_valid = 1'b0;
    standby = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check(ce1_n && !ce2 && oe_n && we_n && !dq_oe && !rsp_valid, "R1 reset strobes",
          {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 idle until request",
          {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // directed corners
    issue(1'b0, 0, 8'h00);            // first access wakes the chip
    issue(1'b1, 8191, 8'hA7);
    issue(1'b0, 8191, 8'h00);         // read after write, top address
    issue(1'b0, 3, 8'h00);
    issue(1'b1, 3, 8'h5A);            // write right after read: turnaround
    issue(1'b0, 3, 8'h00);
    standby_trip(0);
    issue(1'b1, 12, 8'hC3);           // write straight out of standby
    issue(1'b0, 12, 8'h00);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      automatic int op = int'($urandom % 16);
      automatic int a = ($urandom % 4 == 0) ? int'($urandom % 8192) : int'($urandom % 16);
      if (op == 15) standby_trip(int'($urandom % 4));
      else if (op < 7) issue(1'b1, a, 8'($urandom));
      else issue(1'b0, a, 8'h00);
      if ($urandom % 5 == 0) repeat ($urandom % 4) @(negedge clk);
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    finish_run();
  end

endmodule